// File: doc/BRIEF.md
# Codec Frame Sync Generator

This block produces the bit, word and frame timing for a serial link to an audio codec. Running from the bit clock, it counts cycles into words and words into frames. It either drives a frame sync output in one of four framing styles or, as a follower, realigns its counters to a frame sync that arrives from outside. The block reports where the link is within the frame through a bit count, a word count, a strobe at the start of each word and a strobe at the start of each frame. A shifter elsewhere in the design uses these to move serial data.

Software places a mode, a word size and a frame length on the configuration inputs while the block is disabled, and then raises the enable. The block latches the configuration only while it is disabled, so the timing stays fixed for as long as the enable is held. Two of the styles use the programmable sizes. The other two use a fixed 256-cycle frame whose slot layout is set by the style.

Top module: `codec_fsync_gen`

## Requirements
- R1: In modes 2'b00 and 2'b01, a word lasts `wordSize`+1 bit-clock cycles. `bitCount` runs from 0 up to `wordSize` and `wordStrobe` is high in every cycle where `bitCount` is 0.
- R2: In modes 2'b00 and 2'b01, a frame holds `frameLen`+1 words, which gives (`wordSize`+1)·(`frameLen`+1) cycles. `wordCount` runs from 0 up to `frameLen`, and `frameStrobe` is high only when both counts are 0.
- R3: Mode 2'b00 (multi-channel), as driver: `fsyncOut` is high for exactly the first cycle of every frame and low in all other cycles.
- R4: Mode 2'b01 (I2S), as driver: with a frame of L cycles, `fsyncOut` is high in frame cycles 0 to floor(L/2)−1 and low for the rest of the frame.
- R5: Mode 2'b10 (AC-Link, equal slots): the frame has 16 words of 16 bits, 256 cycles in all. `fsyncOut` is high during word 0 (16 cycles) and low for the other 240 cycles. `wordSize` and `frameLen` have no effect.
- R6: Mode 2'b11 (AC-Link, wide slots): word 0 has 16 bits and is followed by 12 words of 20 bits, 256 cycles in all. `bitCount` reaches at most 19, `wordCount` reaches at most 12, and `fsyncOut` is high for the first 16 cycles.
- R7: While `enable` is low, both counts, both strobes and `fsyncOut` are 0. The first enabled cycle is bit 0 of word 0.
- R8: While `slaveSel` is 1, `fsyncOut` stays 0.
- R9: While `slaveSel` is 1, the counters reload when `fsyncIn` changes between two consecutive enabled cycles: on a 0→1 change in modes 2'b00, 2'b10 and 2'b11, and on either change in mode 2'b01. `fsyncIn` counts as 0 before the first enabled cycle. After a reload, the next cycle shows bit 0 of word 0.
- R10: The block latches `modeSel`, `wordSize` and `frameLen` only while `enable` is low. A change on these inputs while enabled does not alter the timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run when high; clears the counters and latches the configuration when low |
| slaveSel | input | 1 | 0: drive frame sync; 1: follow fsyncIn |
| modeSel | input | 2 | Framing style: 00 multi-channel, 01 I2S, 10 AC-Link equal slots, 11 AC-Link wide slots |
| wordSize | input | 4 | Word length minus one |
| frameLen | input | 4 | Words per frame minus one |
| fsyncIn | input | 1 | External frame sync used in follower mode |
| fsyncOut | output | 1 | Generated frame sync |
| wordStrobe | output | 1 | High in the first cycle of each word |
| frameStrobe | output | 1 | High in the first cycle of each frame |
| wordCount | output | 4 | Word index within the frame |
| bitCount | output | 5 | Bit index within the word |

## Verification
Several properties are checked on every cycle, whatever the configuration: the counters clear while the block is idle, the bit and word counts advance one step at a time, a follower never drives frame sync, the multi-channel pulse coincides with the frame strobe, and an AC-Link frame opens with frame sync high. The exact frame periods, the I2S half-period split, the slot layout of the wide AC-Link style, the reload that follows an external sync edge, and the fact that configuration changes made while enabled are ignored all depend on history over whole frames. Only the bench's sweeps can show these, as it compares each cycle against positions computed from the cycle index.

// File: rtl/fsync_pkg.sv
package fsync_pkg;
  localparam int FIELD_W = 4;
  localparam int BIT_W   = 5;
  localparam int CYC_W   = 8;

  typedef enum logic [1:0] {
    MODE_MULTI = 2'b00,
    MODE_I2S   = 2'b01,
    MODE_AC16  = 2'b10,
    MODE_AC20  = 2'b11
  } fsMode_t;

  typedef struct packed {
    logic restart;
    logic wordWrap;
  } fsStrobe_t;
endpackage

// File: rtl/fsync_datapath.sv
module fsync_datapath
  import fsync_pkg::*;
#(
  parameter int FW = FIELD_W,
  parameter int BW = BIT_W,
  parameter int CW = CYC_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          enable,
  input  fsMode_t       modeIn,
  input  logic [FW-1:0] wsIn,
  input  logic [FW-1:0] flIn,
  input  logic          fsyncIn,
  input  fsStrobe_t     strobes,
  output fsMode_t       cfgMode,
  output logic [FW-1:0] cfgWs,
  output logic [FW-1:0] cfgFl,
  output logic [BW-1:0] bitCnt,
  output logic [FW-1:0] wordCnt,
  output logic [CW-1:0] cycCnt,
  output logic          fsyncPrev
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgMode   <= MODE_MULTI;
      cfgWs     <= '0;
      cfgFl     <= '0;
      bitCnt    <= '0;
      wordCnt   <= '0;
      cycCnt    <= '0;
      fsyncPrev <= 1'b0;
    end else if (!enable) begin
      // idle: clear position, take a fresh configuration
      cfgMode   <= modeIn;
      cfgWs     <= wsIn;
      cfgFl     <= flIn;
      bitCnt    <= '0;
      wordCnt   <= '0;
      cycCnt    <= '0;
      fsyncPrev <= 1'b0;
    end else begin
      fsyncPrev <= fsyncIn;
      if (strobes.restart) begin
        bitCnt  <= '0;
        wordCnt <= '0;
        cycCnt  <= '0;
      end else if (strobes.wordWrap) begin
        bitCnt  <= '0;
        wordCnt <= wordCnt + 1'b1;
        cycCnt  <= cycCnt + 1'b1;
      end else begin
        bitCnt  <= bitCnt + 1'b1;
        cycCnt  <= cycCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fsync_control.sv
module fsync_control
  import fsync_pkg::*;
#(
  parameter int FW = FIELD_W,
  parameter int BW = BIT_W,
  parameter int CW = CYC_W
) (
  input  logic          enable,
  input  logic          slaveSel,
  input  fsMode_t       cfgMode,
  input  logic [FW-1:0] cfgWs,
  input  logic [FW-1:0] cfgFl,
  input  logic [BW-1:0] bitCnt,
  input  logic [FW-1:0] wordCnt,
  input  logic [CW-1:0] cycCnt,
  input  logic          fsyncIn,
  input  logic          fsyncPrev,
  output fsStrobe_t     strobes,
  output logic          fsyncOut,
  output logic          wordStrobe,
  output logic          frameStrobe
);
  localparam int LW = CW + 1;
  localparam logic [BW-1:0] AC_SHORT_LAST = BW'(15);
  localparam logic [BW-1:0] AC_LONG_LAST  = BW'(19);
  localparam logic [FW-1:0] AC16_LAST_WORD = FW'(15);
  localparam logic [FW-1:0] AC20_LAST_WORD = FW'(12);

  logic [BW-1:0] lastBit;
  logic [FW-1:0] lastWord;
  logic [LW-1:0] wordLen, wordsPer, frameCycles, halfCycles;
  logic          atStart, bitWrap, syncEdge, i2sHigh, genSync;

  always_comb begin
    unique case (cfgMode)
      MODE_AC16: begin
        lastBit  = AC_SHORT_LAST;
        lastWord = AC16_LAST_WORD;
      end
      MODE_AC20: begin
        lastBit  = (wordCnt == '0) ? AC_SHORT_LAST : AC_LONG_LAST;
        lastWord = AC20_LAST_WORD;
      end
      default: begin
        lastBit  = BW'(cfgWs);
        lastWord = cfgFl;
      end
    endcase
  end

  assign wordLen     = LW'(cfgWs) + 1'b1;
  assign wordsPer    = LW'(cfgFl) + 1'b1;
  assign frameCycles = wordLen * wordsPer;
  assign halfCycles  = frameCycles >> 1;
  assign i2sHigh     = LW'(cycCnt) < halfCycles;

  assign atStart  = (bitCnt == '0) && (wordCnt == '0);
  assign bitWrap  = (bitCnt == lastBit);
  assign syncEdge = slaveSel && ((cfgMode == MODE_I2S) ? (fsyncIn ^ fsyncPrev)
                                                       : (fsyncIn & ~fsyncPrev));

  assign strobes.wordWrap = bitWrap;
  assign strobes.restart  = syncEdge || (bitWrap && (wordCnt == lastWord));

  always_comb begin
    unique case (cfgMode)
      MODE_MULTI: genSync = atStart;
      MODE_I2S:   genSync = i2sHigh;
      default:    genSync = (wordCnt == '0);
    endcase
  end

  assign fsyncOut    = enable && !slaveSel && genSync;
  assign wordStrobe  = enable && (bitCnt == '0);
  assign frameStrobe = enable && atStart;
endmodule

// File: rtl/codec_fsync_gen.sv
module codec_fsync_gen
  import fsync_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              slaveSel,
  input  logic [1:0]        modeSel,
  input  logic [FIELD_W-1:0] wordSize,
  input  logic [FIELD_W-1:0] frameLen,
  input  logic              fsyncIn,
  output logic              fsyncOut,
  output logic              wordStrobe,
  output logic              frameStrobe,
  output logic [FIELD_W-1:0] wordCount,
  output logic [BIT_W-1:0]  bitCount
);
  fsStrobe_t           strobes;
  fsMode_t             cfgMode;
  logic [FIELD_W-1:0]  cfgWs, cfgFl;
  logic [CYC_W-1:0]    cycCnt;
  logic                fsyncPrev;

  fsync_datapath #(.FW(FIELD_W), .BW(BIT_W), .CW(CYC_W)) u_dp (
    .clk(clk), .rstN(rstN), .enable(enable),
    .modeIn(fsMode_t'(modeSel)), .wsIn(wordSize), .flIn(frameLen),
    .fsyncIn(fsyncIn), .strobes(strobes),
    .cfgMode(cfgMode), .cfgWs(cfgWs), .cfgFl(cfgFl),
    .bitCnt(bitCount), .wordCnt(wordCount), .cycCnt(cycCnt),
    .fsyncPrev(fsyncPrev)
  );

  fsync_control #(.FW(FIELD_W), .BW(BIT_W), .CW(CYC_W)) u_ctl (
    .enable(enable), .slaveSel(slaveSel), .cfgMode(cfgMode),
    .cfgWs(cfgWs), .cfgFl(cfgFl), .bitCnt(bitCount), .wordCnt(wordCount),
    .cycCnt(cycCnt), .fsyncIn(fsyncIn), .fsyncPrev(fsyncPrev),
    .strobes(strobes), .fsyncOut(fsyncOut), .wordStrobe(wordStrobe),
    .frameStrobe(frameStrobe)
  );
endmodule

// File: rtl/fsync_checker.sv
module fsync_checker
  import fsync_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               enable,
  input logic               slaveSel,
  input fsMode_t            cfgMode,
  input logic               fsyncOut,
  input logic               wordStrobe,
  input logic               frameStrobe,
  input logic [FIELD_W-1:0] wordCount,
  input logic [BIT_W-1:0]   bitCount
);
  p_idle_counters_r7: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (bitCount == '0 && wordCount == '0));

  p_slave_silent_r8: assert property (@(posedge clk) disable iff (!rstN)
    slaveSel |-> !fsyncOut);

  p_bit_step_r1: assert property (@(posedge clk) disable iff (!rstN)
    (enable && $past(enable) && bitCount != '0) |-> bitCount == $past(bitCount) + 1'b1);

  p_word_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (enable && $past(enable) && wordStrobe && !frameStrobe)
      |-> wordCount == $past(wordCount) + 1'b1);

  p_multi_sync_r3: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !slaveSel && cfgMode == MODE_MULTI) |-> fsyncOut == frameStrobe);

  p_ac_start_high_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!slaveSel && frameStrobe && (cfgMode == MODE_AC16 || cfgMode == MODE_AC20))
      |-> fsyncOut);

  p_bit_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    bitCount <= BIT_W'(19));
endmodule

bind codec_fsync_gen fsync_checker u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .slaveSel(slaveSel),
  .cfgMode(cfgMode), .fsyncOut(fsyncOut), .wordStrobe(wordStrobe),
  .frameStrobe(frameStrobe), .wordCount(wordCount), .bitCount(bitCount)
);

// File: tb/codec_fsync_gen_test.sv
`timescale 1ns/1ps
module codec_fsync_gen_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic       slaveSel = 1'b0;
  logic [1:0] modeSel = 2'b00;
  logic [3:0] wordSize = 4'd0;
  logic [3:0] frameLen = 4'd0;
  logic       fsyncIn = 1'b0;
  logic       fsyncOut, wordStrobe, frameStrobe;
  logic [3:0] wordCount;
  logic [4:0] bitCount;

  int compared = 0;
  int mismatched = 0;

  always #4 clk = ~clk;

  codec_fsync_gen uut (
    .clk(clk), .rstN(rstN), .enable(enable), .slaveSel(slaveSel),
    .modeSel(modeSel), .wordSize(wordSize), .frameLen(frameLen),
    .fsyncIn(fsyncIn), .fsyncOut(fsyncOut), .wordStrobe(wordStrobe),
    .frameStrobe(frameStrobe), .wordCount(wordCount), .bitCount(bitCount)
  );

  task automatic chk(input string tag, input string what, input int got, input int exp);
    compared++;
    if (got != exp) begin
      mismatched++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  function automatic int frameCycles(input int m, input int ws, input int fl);
    return (m >= 2) ? 256 : (ws + 1) * (fl + 1);
  endfunction

  function automatic void model(input int m, input int ws, input int fl, input int p,
                                output int b, output int w, output int f);
    int len;
    len = frameCycles(m, ws, fl);
    case (m)
      0, 1: begin
        b = p % (ws + 1);
        w = p / (ws + 1);
        f = (m == 0) ? int'(p == 0) : int'(p < len / 2);
      end
      2: begin
        b = p % 16; w = p / 16; f = int'(p < 16);
      end
      default: begin
        if (p < 16) begin b = p; w = 0; end
        else begin b = (p - 16) % 20; w = 1 + (p - 16) / 20; end
        f = int'(p < 16);
      end
    endcase
  endfunction

  task automatic checkPos(input string tagCnt, input string tagSync, input int m,
                          input int ws, input int fl, input int p, input bit follower);
    int b, w, f;
    model(m, ws, fl, p, b, w, f);
    chk(tagCnt, "bitCount", int'(bitCount), b);
    chk(tagCnt, "wordCount", int'(wordCount), w);
    chk(tagCnt, "wordStrobe", int'(wordStrobe), int'(b == 0));
    chk(tagCnt, "frameStrobe", int'(frameStrobe), int'(p == 0));
    chk(tagSync, "fsyncOut", int'(fsyncOut), follower ? 0 : f);
  endtask

  task automatic checkIdle();
    chk("R7", "idle fsyncOut", int'(fsyncOut), 0);
    chk("R7", "idle wordStrobe", int'(wordStrobe), 0);
    chk("R7", "idle frameStrobe", int'(frameStrobe), 0);
    chk("R7", "idle bitCount", int'(bitCount), 0);
    chk("R7", "idle wordCount", int'(wordCount), 0);
  endtask

  task automatic startRun(input int m, input int ws, input int fl, input bit follower);
    @(negedge clk);
    enable = 1'b0; slaveSel = follower; fsyncIn = 1'b0;
    modeSel = 2'(m); wordSize = 4'(ws); frameLen = 4'(fl);
    @(negedge clk);
    checkIdle();
    enable = 1'b1;
    #1;
  endtask

  // driver run over two frames; in the second frame the inputs are scrambled (R10)
  task automatic runCfg(input int m, input int ws, input int fl);
    string tc, ts;
    int len, p;
    len = frameCycles(m, ws, fl);
    case (m)
      0: begin tc = "R1"; ts = "R3"; end
      1: begin tc = "R2"; ts = "R4"; end
      2: begin tc = "R5"; ts = "R5"; end
      default: begin tc = "R6"; ts = "R6"; end
    endcase
    startRun(m, ws, fl, 1'b0);
    p = 0;
    checkPos(tc, ts, m, ws, fl, p, 1'b0);
    for (int n = 1; n < 2 * len + 1; n++) begin
      @(negedge clk);
      p = (p + 1) % len;
      if (n >= len) checkPos("R10", "R10", m, ws, fl, p, 1'b0);
      else          checkPos(tc, ts, m, ws, fl, p, 1'b0);
      if (n == len) begin
        modeSel  = ~2'(m);
        wordSize = ~4'(ws);
        frameLen = 4'(fl) ^ 4'd5;
      end
    end
  endtask

  // follower run: fsyncIn toggled at chosen cycles (R8, R9)
  task automatic runFollow(input int m, input int ws, input int fl,
                           input int e1, input int e2, input int e3);
    int len, p;
    bit prevIn, reload, nxt;
    len = frameCycles(m, ws, fl);
    startRun(m, ws, fl, 1'b1);
    p = 0; prevIn = 1'b0; reload = 1'b0;
    checkPos("R9", "R8", m, ws, fl, p, 1'b1);
    for (int n = 1; n < 3 * len; n++) begin
      nxt = (n == e1 || n == e3) ? 1'b1 : ((n == e2) ? 1'b0 : fsyncIn);
      fsyncIn = nxt;
      reload = (m == 1) ? (nxt != prevIn) : (nxt && !prevIn);
      prevIn = nxt;
      @(negedge clk);
      p = reload ? 0 : (p + 1) % len;
      checkPos("R9", "R8", m, ws, fl, p, 1'b1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checkIdle();
    rstN = 1'b1;
    @(negedge clk);
    checkIdle();
    for (int m = 0; m < 2; m++)
      for (int ws = 0; ws < 8; ws++)
        for (int fl = 0; fl < 8; fl++)
          runCfg(m, ws, fl);
    runCfg(0, 15, 15);
    runCfg(1, 15, 15);
    runCfg(1, 15, 0);
    runCfg(0, 0, 15);
    runCfg(1, 2, 2);
    runCfg(2, 3, 1);
    runCfg(2, 15, 15);
    runCfg(3, 0, 0);
    runCfg(3, 9, 6);
    runFollow(0, 3, 3, 5, 9, 21);
    runFollow(1, 2, 3, 4, 7, 20);
    runFollow(2, 0, 0, 40, 50, 300);
    runFollow(3, 0, 0, 100, 120, 400);
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    checkIdle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: run did not complete, got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule